// File: doc/BRIEF.md
# Dual-Path Hammock Fetch Sequencer

This block sits in the fetch stage. It takes a short forward conditional branch whose both arms are known in advance (a hammock) and fetches both arms instead of guessing a direction. A table of four hammock descriptors is loaded at reset. Each descriptor holds the branch address, the start and length of the taken arm, the start and length of the fall-through arm, and the merge address. When the fetched address matches a descriptor exactly, the sequencer takes the branch out of the normal stream. It then emits a synthetic predicate-producing op, every instruction of the taken arm, every instruction of the fall-through arm, and a synthetic conditional-move op, in that order. After that it hands fetch back at the merge address.

Each instruction the sequencer emits is marked with a kind code and a control-dependent flag. Arm instructions also carry a guard tag and a polarity bit. The guard tag is the rename-provided identifier of the predicate register, and later stages use it to cancel the arm whose condition is false. While a hammock is in progress the normal branch-target lookup is disabled, and the next fetch address is the merge address. A mispredict reported by the second fetch stage belongs to an older branch, so it abandons any hammock in progress.

Top module: `hammock_fetch_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the sequencer is idle: `btb_lookup_en` is 1 and `out_kind` is 0 (normal).
- R2: When idle, the fetched instruction passes straight through. `out_valid` equals `fetch_valid`, `out_pc` equals `fetch_pc`, `out_kind` is 0, `out_cd`, `out_tag` and `out_pol` are 0, `btb_lookup_en` is 1 and `next_pc` equals `btb_pc`.
- R3: When idle, a fetched address that exactly equals a table branch address is a hit. The hit instruction is not emitted (`out_valid` is 0), and once `fetch_ready` is high the sequencer moves to the predicate state. An address that differs from every entry, even by one instruction, is not a hit.
- R4: In the predicate state the block emits kind 1 with `out_pc` set to the branch address, `out_cd` 0, `out_pol` 0 and `out_tag` equal to the live `guard_id`. That `guard_id` value is captured when the op is accepted.
- R5: In the taken-arm state the block emits kind 2, with the k-th instruction (counting from 0) at the taken start plus 4k. These instructions carry `out_cd` 1, `out_pol` 1 and the captured tag, and the state has exactly as many instructions as the taken length.
- R6: In the fall-through state the block emits kind 2 at the fall-through start plus 4k, for exactly the fall-through length. These instructions carry `out_cd` 1, `out_pol` 0 and the captured tag.
- R7: An arm whose length is 0 is skipped entirely. The next non-empty state follows directly.
- R8: In the merge state the block emits kind 3 at the branch address, with `out_cd` 0, `out_pol` 0 and the captured tag. Once this op is accepted the sequencer returns to idle.
- R9: While `out_ready` is 0 in a non-idle state, the state, the arm counter and all outputs hold.
- R10: `mispredict` forces the sequencer to idle on the next cycle. It takes priority over every other transition.
- R11: `fetch_ready` equals `out_ready` while idle and is 0 otherwise. Outside idle, `btb_lookup_en` is 0 and `next_pc` is the merge address of the active entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; loads the descriptor table |
| fetch_valid | input | 1 | Fetched instruction available |
| fetch_pc | input | 32 | Address of fetched instruction |
| fetch_ready | output | 1 | Fetched instruction consumed this cycle |
| btb_pc | input | 32 | Next address from the normal target lookup |
| btb_lookup_en | output | 1 | Normal target lookup enabled (idle only) |
| next_pc | output | 32 | Address the front end fetches next |
| mispredict | input | 1 | Older-branch mispredict from the second fetch stage |
| guard_id | input | 6 | Rename identifier of the predicate register |
| out_ready | input | 1 | Downstream bundle accepts an instruction |
| out_valid | output | 1 | Emitted instruction valid |
| out_kind | output | 2 | 0 normal, 1 predicate op, 2 arm instruction, 3 conditional move |
| out_pc | output | 32 | Address of emitted instruction |
| out_cd | output | 1 | Control-dependent flag |
| out_tag | output | 6 | Guard tag |
| out_pol | output | 1 | 1 for taken-arm instructions |

## Verification
The hardest situations to reach from the ports are a mispredict that lands partway through an arm, and a downstream stall on the last instruction of an arm, just as the arm counter would wrap into the next state. Neither happens in an ordinary directed walk. The stimulus steers about half of the fetched addresses onto table branch addresses, so hammocks start often. It also drops `out_ready` a quarter of the time and raises `mispredict` at random, so across thousands of cycles both events land at every position within every arm, including the zero-length arms of entries 2 and 3.

// File: rtl/hammock_fetch_seq.sv
module hammock_fetch_seq #(
  parameter int PC_W    = 32,
  parameter int TAG_W   = 6,
  parameter int LEN_W   = 4,
  parameter int ENTRIES = 4,
  parameter logic [ENTRIES*PC_W-1:0]  HT_BR  = {32'h400, 32'h300, 32'h200, 32'h100},
  parameter logic [ENTRIES*PC_W-1:0]  HT_TS  = {32'h410, 32'h310, 32'h210, 32'h110},
  parameter logic [ENTRIES*LEN_W-1:0] HT_TL  = {4'd2, 4'd0, 4'd1, 4'd3},
  parameter logic [ENTRIES*PC_W-1:0]  HT_NS  = {32'h420, 32'h320, 32'h220, 32'h120},
  parameter logic [ENTRIES*LEN_W-1:0] HT_NL  = {4'd0, 4'd2, 4'd4, 4'd2},
  parameter logic [ENTRIES*PC_W-1:0]  HT_MG  = {32'h440, 32'h340, 32'h240, 32'h140}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic [PC_W-1:0]  fetch_pc,
  output logic             fetch_ready,
  input  logic [PC_W-1:0]  btb_pc,
  output logic             btb_lookup_en,
  output logic [PC_W-1:0]  next_pc,
  input  logic             mispredict,
  input  logic [TAG_W-1:0] guard_id,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [1:0]       out_kind,
  output logic [PC_W-1:0]  out_pc,
  output logic             out_cd,
  output logic [TAG_W-1:0] out_tag,
  output logic             out_pol
);
  localparam int IDX_W       = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int INSTR_BYTES = 4;
  localparam logic [1:0] K_NORM = 2'd0, K_PRED = 2'd1, K_ARM = 2'd2, K_CMOV = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_PRED, S_ARM_T, S_ARM_N, S_CMOV} state_t;

  state_t             state;
  logic [IDX_W-1:0]   ent;
  logic [LEN_W-1:0]   cnt;
  logic [TAG_W-1:0]   gtag;

  logic [PC_W-1:0]  tb_br [ENTRIES];
  logic [PC_W-1:0]  tb_ts [ENTRIES];
  logic [PC_W-1:0]  tb_ns [ENTRIES];
  logic [PC_W-1:0]  tb_mg [ENTRIES];
  logic [LEN_W-1:0] tb_tl [ENTRIES];
  logic [LEN_W-1:0] tb_nl [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_tbl
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        tb_br[g] <= HT_BR[g*PC_W +: PC_W];
        tb_ts[g] <= HT_TS[g*PC_W +: PC_W];
        tb_ns[g] <= HT_NS[g*PC_W +: PC_W];
        tb_mg[g] <= HT_MG[g*PC_W +: PC_W];
        tb_tl[g] <= HT_TL[g*LEN_W +: LEN_W];
        tb_nl[g] <= HT_NL[g*LEN_W +: LEN_W];
      end
  end

  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (!hit && tb_br[i] == fetch_pc) begin
        hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
  end

  wire idle   = (state == S_IDLE);
  wire fire   = out_valid && out_ready;
  wire last_t = ({1'b0, cnt} + 1'b1) == {1'b0, tb_tl[ent]};
  wire last_n = ({1'b0, cnt} + 1'b1) == {1'b0, tb_nl[ent]};
  wire [PC_W-1:0] offs = PC_W'(cnt) * PC_W'(INSTR_BYTES);

  state_t after_pred, after_taken;
  assign after_taken = (tb_nl[ent] != '0) ? S_ARM_N : S_CMOV;
  assign after_pred  = (tb_tl[ent] != '0) ? S_ARM_T : after_taken;

  assign fetch_ready   = idle && out_ready;
  assign btb_lookup_en = idle;
  assign next_pc       = idle ? btb_pc : tb_mg[ent];
  assign out_valid     = idle ? (fetch_valid && !hit) : 1'b1;
  assign out_cd        = (state == S_ARM_T) || (state == S_ARM_N);
  assign out_pol       = (state == S_ARM_T);

  always_comb begin
    out_kind = K_NORM;
    out_pc   = fetch_pc;
    out_tag  = '0;
    case (state)
      S_PRED:  begin out_kind = K_PRED; out_pc = tb_br[ent];        out_tag = guard_id; end
      S_ARM_T: begin out_kind = K_ARM;  out_pc = tb_ts[ent] + offs; out_tag = gtag;     end
      S_ARM_N: begin out_kind = K_ARM;  out_pc = tb_ns[ent] + offs; out_tag = gtag;     end
      S_CMOV:  begin out_kind = K_CMOV; out_pc = tb_br[ent];        out_tag = gtag;     end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ent   <= '0;
      cnt   <= '0;
      gtag  <= '0;
    end else if (mispredict) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (fetch_valid && fetch_ready && hit) begin
            state <= S_PRED;
            ent   <= hit_idx;
            cnt   <= '0;
          end
        S_PRED:
          if (fire) begin
            gtag  <= guard_id;
            state <= after_pred;
          end
        S_ARM_T:
          if (fire) begin
            cnt <= last_t ? '0 : cnt + 1'b1;
            if (last_t) state <= after_taken;
          end
        S_ARM_N:
          if (fire) begin
            cnt <= last_n ? '0 : cnt + 1'b1;
            if (last_n) state <= S_CMOV;
          end
        S_CMOV:
          if (fire) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> state == S_IDLE);

  p_cd_off_lookup_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_cd |-> !btb_lookup_en && !fetch_ready);

  p_hit_to_pred_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready && hit && !mispredict |=> out_valid && out_kind == K_PRED);

  p_injected_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_kind == K_PRED || out_kind == K_CMOV) |-> !out_cd && !out_pol);

  p_cmov_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_kind == K_CMOV && out_ready && !mispredict |=> state == S_IDLE);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state != S_IDLE && state != S_PRED && !out_ready && !mispredict |=>
      $stable(out_pc) && $stable(out_kind) && $stable(out_tag) && $stable(out_pol));

  p_mispredict_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |=> state == S_IDLE);
endmodule

// File: tb/hammock_fetch_seq_tb.sv
module hammock_fetch_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic [31:0] btb_pc = '0;
  logic        mispredict = 1'b0;
  logic [5:0]  guard_id = '0;
  logic        out_ready = 1'b0;
  logic        fetch_ready, btb_lookup_en, out_valid, out_cd, out_pol;
  logic [31:0] next_pc, out_pc;
  logic [1:0]  out_kind;
  logic [5:0]  out_tag;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hammock_fetch_seq dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .fetch_ready(fetch_ready), .btb_pc(btb_pc), .btb_lookup_en(btb_lookup_en),
    .next_pc(next_pc), .mispredict(mispredict), .guard_id(guard_id),
    .out_ready(out_ready), .out_valid(out_valid), .out_kind(out_kind),
    .out_pc(out_pc), .out_cd(out_cd), .out_tag(out_tag), .out_pol(out_pol));

  function automatic logic [31:0] e_br(int i); return 32'h100 * (i + 1); endfunction
  function automatic logic [31:0] e_ts(int i); return e_br(i) + 32'h10; endfunction
  function automatic logic [31:0] e_ns(int i); return e_br(i) + 32'h20; endfunction
  function automatic logic [31:0] e_mg(int i); return e_br(i) + 32'h40; endfunction
  function automatic int e_tl(int i); int t[4] = '{3, 1, 0, 2}; return t[i]; endfunction
  function automatic int e_nl(int i); int t[4] = '{2, 4, 2, 0}; return t[i]; endfunction
  function automatic int m_hit(logic [31:0] pc);
    for (int i = 0; i < 4; i++) if (pc == e_br(i)) return i;
    return -1;
  endfunction

  // model: 0 idle, 1 pred, 2 taken arm, 3 fall-through arm, 4 merge
  int m_st = 0, m_ent = 0, m_cnt = 0;
  logic [5:0] m_tag = '0;
  logic m_prev_mp = 1'b0;

  task automatic compare(string req);
    logic [110:0] exp_v, act_v;
    logic ev, ecd, epol, efr, ele;
    logic [1:0] ek;
    logic [31:0] epc, enp;
    logic [5:0] etag;
    int h = m_hit(fetch_pc);
    ev = 1; ek = 0; epc = fetch_pc; ecd = 0; etag = 0; epol = 0;
    efr = 0; ele = 0; enp = e_mg(m_ent);
    case (m_st)
      0: begin ev = fetch_valid && (h < 0); efr = out_ready; ele = 1; enp = btb_pc; end
      1: begin ek = 1; epc = e_br(m_ent); etag = guard_id; end
      2: begin ek = 2; epc = e_ts(m_ent) + 4 * m_cnt; ecd = 1; epol = 1; etag = m_tag; end
      3: begin ek = 2; epc = e_ns(m_ent) + 4 * m_cnt; ecd = 1; etag = m_tag; end
      default: begin ek = 3; epc = e_br(m_ent); etag = m_tag; end
    endcase
    exp_v = {ev, ek, epc, ecd, etag, epol, efr, ele, enp};
    act_v = {out_valid, out_kind, out_pc, out_cd, out_tag, out_pol, fetch_ready, btb_lookup_en, next_pc};
    n_cmp++;
    if (exp_v !== act_v) begin
      n_bad++;
      $display("FAIL %s: act v%0b k%0d pc%h cd%0b tag%0d pol%0b fr%0b le%0b np%h / exp v%0b k%0d pc%h cd%0b tag%0d pol%0b fr%0b le%0b np%h",
        req, out_valid, out_kind, out_pc, out_cd, out_tag, out_pol, fetch_ready, btb_lookup_en, next_pc,
        ev, ek, epc, ecd, etag, epol, efr, ele, enp);
    end
  endtask

  function automatic string label();
    if (m_prev_mp) return "R10";
    if (m_st != 0 && !out_ready) return "R9";
    case (m_st)
      0: return (m_hit(fetch_pc) >= 0) ? "R3" : "R2 R11";
      1: return "R4";
      2: return "R5";
      3: return (e_tl(m_ent) == 0) ? "R6 R7" : "R6";
      default: return (e_nl(m_ent) == 0) ? "R8 R7" : "R8";
    endcase
  endfunction

  task automatic advance();
    int h = m_hit(fetch_pc);
    logic rdy = out_ready;
    m_prev_mp = mispredict;
    if (mispredict) begin m_st = 0; m_cnt = 0; end
    else case (m_st)
      0: if (fetch_valid && rdy && h >= 0) begin m_st = 1; m_ent = h; m_cnt = 0; end
      1: if (rdy) begin
           m_tag = guard_id;
           m_st = (e_tl(m_ent) != 0) ? 2 : (e_nl(m_ent) != 0) ? 3 : 4;
         end
      2: if (rdy) begin
           if (m_cnt + 1 == e_tl(m_ent)) begin m_cnt = 0; m_st = (e_nl(m_ent) != 0) ? 3 : 4; end
           else m_cnt++;
         end
      3: if (rdy) begin
           if (m_cnt + 1 == e_nl(m_ent)) begin m_cnt = 0; m_st = 4; end
           else m_cnt++;
         end
      default: if (rdy) m_st = 0;
    endcase
  endtask

  task automatic step(logic fv, logic [31:0] pc, logic rdy, logic mp);
    @(negedge clk);
    fetch_valid = fv; fetch_pc = pc; out_ready = rdy; mispredict = mp;
    guard_id = 6'($urandom); btb_pc = $urandom;
    #1;
    compare(label());
    advance();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: act running / exp finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    // R1: reset state
    repeat (2) begin
      @(negedge clk); out_ready = 1; fetch_valid = 1; fetch_pc = 32'h104; #1;
      compare("R1");
    end
    @(negedge clk); rst_n = 1;
    #1; compare("R1");
    // directed walks: each entry without stalls, then with stalls
    for (int e = 0; e < 4; e++) begin
      step(1, e_br(e), 1, 0);
      repeat (9) step(1, 32'h80, 1, 0);
    end
    step(1, e_br(1), 1, 0);
    repeat (3) step(1, 32'h80, 1, 0);
    step(1, 32'h80, 1, 1);                 // R10: abandon mid arm
    step(1, e_br(0) + 4, 1, 0);            // R3: near miss
    step(1, e_br(0), 1, 0);
    for (int k = 0; k < 14; k++) step(1, 32'h80, (k % 2) == 0, 0); // R9 stalls
    // constrained random
    for (int c = 0; c < 6000; c++) begin
      int sel = $urandom % 8;
      logic [31:0] pc;
      pc = (sel < 4) ? e_br(sel) : (sel == 4) ? e_br($urandom % 4) + 4 :
           (sel == 5) ? e_br($urandom % 4) - 4 : 32'($urandom % 4096) << 2;
      step(($urandom % 4) != 0, pc, ($urandom % 4) != 0, ($urandom % 40) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule